// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds the address and count state of a single DMA channel and produces the 24-bit byte address for each transferred byte. A CPU writes the channel through a byte-wide register port. Two 16-bit quantities, the start address and the byte count, are reached one byte at a time through a shared byte pointer. A third register, the 8-bit page, supplies the upper address byte. The current address and current count can be read back through the same port. The start address is write-only. The start count is write-only too, and it exists only as the value it places in the current count.

A transfer engine outside the block offers one step per moved byte on a valid/ready pair. Each accepted step advances the current address and counts the current count down. A static mode input selects what happens at a 64 KiB boundary. In the first mode the address wraps inside its 64 KiB window. In the second mode the page is bumped so the transfer carries on into the next window. In the third mode the address is a single 24-bit counter. That counter is reloaded from the page and the start address whenever the page is written. Back-pressure rule: `step_ready` is low while terminal count is set and in any cycle with a register write. A step is taken only in a cycle where both `step_valid` and `step_ready` are high. The engine may hold `step_valid` high across stalls.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the current address, start address, page, current count, byte pointer and terminal-count flag are all zero. `xfer_addr` reads 0, `tc` reads 0 and `step_ready` reads 1.
- R2: `reg_sel` encodes 0 = address, 1 = count, 2 = page, 3 = pointer clear. Each read or write at select 0 or 1 accesses the low byte when the pointer is 0 and the high byte when it is 1, then toggles the pointer. A write at select 3 sets the pointer to 0.
- R3: Writing one byte of the start address or count copies that byte into the same byte of the current register. The other byte of the current register is left unchanged.
- R4: An accepted step adds one to the current address and subtracts one from the current count.
- R5: In mode 0 (also used for code 3), `xfer_addr` is {page, current[15:0]}. A step from low half FFFFh gives 0000h, and the page is unchanged.
- R6: In mode 1, a step that rolls the low half from FFFFh to 0000h also adds one to the page. The new page is visible on `xfer_addr` and on a page read.
- R7: In mode 2, the current address is 24 bits wide and carries across 64 KiB boundaries. `xfer_addr` equals it, and a page read returns its bits 23:16.
- R8: In mode 2, a page write loads the current address with {written page, start address}, even in the middle of a transfer.
- R9: In modes 0 and 1, a page write changes only the page. The current address and the current count keep their values.
- R10: A step taken while the count is 0000h sets the count to FFFFh and raises `tc`, so a count of N moves N+1 bytes.
- R11: While `tc` is high, `step_ready` is low and steps change nothing. A write to either count byte clears `tc`.
- R12: `step_ready` is low in every cycle in which `reg_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Boundary policy: 0 wrap, 1 page step, 2 linear, 3 as 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances byte pointer) |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| step_valid | input | 1 | Transfer engine offers one byte step |
| step_ready | output | 1 | Block accepts a step this cycle |
| xfer_addr | output | 24 | Byte address of the current transfer |
| tc | output | 1 | Terminal count reached |

## Verification
If the byte pointer is in the wrong state, the wrong half of a 16-bit register is written or read. A bad pointer therefore shows on `reg_rdata` at the very next access, and on `xfer_addr` right after the next address write. An error in the carry or page logic shows on `xfer_addr` one cycle after the step that crosses FFFFh. An error in the count path shows as `tc` and `step_ready` switching one step early or late. Because a reference model is compared on every clock, any such divergence is reported in the first cycle in which it reaches a port.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP      = 2'd0,
    MODE_PAGE_STEP = 2'd1,
    MODE_LINEAR    = 2'd2,
    MODE_RSVD      = 2'd3
  } bnd_mode_e;

  typedef enum logic [1:0] {
    SEL_ADDR    = 2'd0,
    SEL_CNT     = 2'd1,
    SEL_PAGE    = 2'd2,
    SEL_PTR_CLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dag_byte_ptr.sv
module dag_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clear,
  output logic hi_sel
);
  logic ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= 1'b0;
    else if (clear)  ptr_q <= 1'b0;
    else if (toggle) ptr_q <= ~ptr_q;
  end

  assign hi_sel = ptr_q;

  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hi_sel);

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && !clear) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dag_addr_path.sv
module dag_addr_path
  import dag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned LO_W   = 2 * DATA_W,
  localparam int unsigned ADDR_W = LO_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bnd_mode_e         mode,
  input  logic              wr_addr,
  input  logic              wr_page,
  input  logic              hi_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [LO_W-1:0]   cur_lo,
  output logic [PAGE_W-1:0] page_view
);
  logic [LO_W-1:0]   base_q;
  logic [ADDR_W-1:0] cur_q;
  logic [PAGE_W-1:0] page_q;
  logic [LO_W-1:0]   lo_next;
  logic              lo_carry;
  logic              is_linear;
  logic [PAGE_W-1:0] page_wr;

  assign is_linear = (mode == MODE_LINEAR);
  assign lo_next   = cur_q[LO_W-1:0] + LO_W'(1);
  assign lo_carry  = &cur_q[LO_W-1:0];
  assign page_wr   = PAGE_W'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      page_q <= '0;
    end else begin
      if (wr_addr) begin
        base_q[hi_sel*DATA_W +: DATA_W] <= wdata;
        cur_q[hi_sel*DATA_W +: DATA_W]  <= wdata;
      end
      if (wr_page) begin
        page_q <= page_wr;
        if (is_linear) cur_q <= {page_wr, base_q};
      end
      if (step) begin
        unique case (mode)
          MODE_LINEAR: cur_q <= cur_q + ADDR_W'(1);
          MODE_PAGE_STEP: begin
            cur_q[LO_W-1:0] <= lo_next;
            if (lo_carry) page_q <= page_q + PAGE_W'(1);
          end
          default: cur_q[LO_W-1:0] <= lo_next;
        endcase
      end
    end
  end

  assign xfer_addr = is_linear ? cur_q : {page_q, cur_q[LO_W-1:0]};
  assign cur_lo    = cur_q[LO_W-1:0];
  assign page_view = is_linear ? cur_q[ADDR_W-1:LO_W] : page_q;

  // R5
  wrap_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (mode == MODE_WRAP) && lo_carry) |=>
      (cur_q[LO_W-1:0] == '0) && (page_q == $past(page_q)));

  // R6
  page_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (mode == MODE_PAGE_STEP) && lo_carry) |=>
      (page_q == $past(page_q) + PAGE_W'(1)));

  // R8
  linear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_page && is_linear && !step) |=>
      (xfer_addr == {$past(page_wr), $past(base_q)}));

  // R9
  page_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_page && !is_linear && !step && !wr_addr) |=> $stable(cur_q));
endmodule

// File: rtl/dag_count_path.sv
module dag_count_path #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              tc
);
  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q[hi_sel*DATA_W +: DATA_W] <= wdata;
      tc_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == '0) tc_q <= 1'b1;
    end
  end

  assign cur_cnt = cnt_q;
  assign tc      = tc_q;

  // R10
  tc_on_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt && (cnt_q == '0)) |=> (tc && (&cur_cnt)));

  // R11
  frozen_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !wr_cnt) |=> $stable(cur_cnt));

  // R11
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> !tc);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned LO_W   = 2 * DATA_W,
  localparam int unsigned ADDR_W = LO_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              step_valid,
  output logic              step_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              tc
);
  bnd_mode_e         mode_e;
  reg_sel_e          sel_e;
  logic              hi_sel;
  logic              wide_access;
  logic              ptr_clear;
  logic              wr_addr;
  logic              wr_cnt;
  logic              wr_page;
  logic              step;
  logic [LO_W-1:0]   cur_lo;
  logic [LO_W-1:0]   cur_cnt;
  logic [PAGE_W-1:0] page_view;
  logic              tc_int;

  assign mode_e = bnd_mode_e'(mode);
  assign sel_e  = reg_sel_e'(reg_sel);

  assign wide_access = (reg_wr || reg_rd) && (sel_e == SEL_ADDR || sel_e == SEL_CNT);
  assign ptr_clear   = reg_wr && (sel_e == SEL_PTR_CLR);
  assign wr_addr     = reg_wr && (sel_e == SEL_ADDR);
  assign wr_cnt      = reg_wr && (sel_e == SEL_CNT);
  assign wr_page     = reg_wr && (sel_e == SEL_PAGE);

  assign step_ready = !tc_int && !reg_wr;
  assign step       = step_valid && step_ready;

  dag_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (wide_access),
    .clear  (ptr_clear),
    .hi_sel (hi_sel)
  );

  dag_addr_path #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_e),
    .wr_addr   (wr_addr),
    .wr_page   (wr_page),
    .hi_sel    (hi_sel),
    .wdata     (reg_wdata),
    .step      (step),
    .xfer_addr (xfer_addr),
    .cur_lo    (cur_lo),
    .page_view (page_view)
  );

  dag_count_path #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cnt  (wr_cnt),
    .hi_sel  (hi_sel),
    .wdata   (reg_wdata),
    .step    (step),
    .cur_cnt (cur_cnt),
    .tc      (tc_int)
  );

  always_comb begin
    unique case (sel_e)
      SEL_ADDR: reg_rdata = cur_lo[hi_sel*DATA_W +: DATA_W];
      SEL_CNT:  reg_rdata = cur_cnt[hi_sel*DATA_W +: DATA_W];
      SEL_PAGE: reg_rdata = DATA_W'(page_view);
      default:  reg_rdata = '0;
    endcase
  end

  assign tc = tc_int;

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_e == MODE_LINEAR) |=> (xfer_addr == $past(xfer_addr) + ADDR_W'(1)));

  // R12
  write_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !step);
endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        step_valid = 1'b0;
  logic        step_ready;
  logic [23:0] xfer_addr;
  logic        tc;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  dma_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .step_valid(step_valid), .step_ready(step_ready),
    .xfer_addr(xfer_addr), .tc(tc)
  );

  // Behavioural reference model
  int m_base, m_cur, m_page, m_cnt, m_ptr, m_tc;

  function automatic int m_ready();
    return (m_tc == 0 && !reg_wr) ? 1 : 0;
  endfunction

  function automatic int m_addr();
    if (mode == 2'd2) return m_cur & 24'hFFFFFF;
    return ((m_page & 8'hFF) << 16) | (m_cur & 16'hFFFF);
  endfunction

  function automatic int m_rdata();
    case (reg_sel)
      2'd0: return (m_cur >> (m_ptr * 8)) & 8'hFF;
      2'd1: return (m_cnt >> (m_ptr * 8)) & 8'hFF;
      2'd2: return (mode == 2'd2) ? ((m_cur >> 16) & 8'hFF) : m_page;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_cur = 0; m_page = 0; m_cnt = 0; m_ptr = 0; m_tc = 0;
    end else begin
      int take;
      take = (step_valid && m_ready() != 0) ? 1 : 0;
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin
            if (m_ptr == 0) begin
              m_base = (m_base & 16'hFF00) | reg_wdata;
              m_cur  = (m_cur & 24'hFFFF00) | reg_wdata;
            end else begin
              m_base = (m_base & 16'h00FF) | (reg_wdata << 8);
              m_cur  = (m_cur & 24'hFF00FF) | (reg_wdata << 8);
            end
            m_ptr = 1 - m_ptr;
          end
          2'd1: begin
            if (m_ptr == 0) m_cnt = (m_cnt & 16'hFF00) | reg_wdata;
            else            m_cnt = (m_cnt & 16'h00FF) | (reg_wdata << 8);
            m_ptr = 1 - m_ptr;
            m_tc = 0;
          end
          2'd2: begin
            m_page = reg_wdata;
            if (mode == 2'd2) m_cur = (reg_wdata << 16) | m_base;
          end
          default: m_ptr = 0;
        endcase
      end else if (reg_rd && (reg_sel == 2'd0 || reg_sel == 2'd1)) begin
        m_ptr = 1 - m_ptr;
      end
      if (take != 0) begin
        if (m_cnt == 0) begin m_cnt = 16'hFFFF; m_tc = 1; end
        else m_cnt = m_cnt - 1;
        if (mode == 2'd2) m_cur = (m_cur + 1) & 24'hFFFFFF;
        else begin
          if ((m_cur & 16'hFFFF) == 16'hFFFF && mode == 2'd1) m_page = (m_page + 1) & 8'hFF;
          m_cur = (m_cur & 24'hFF0000) | ((m_cur + 1) & 16'hFFFF);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison with the model, away from the edge
  always @(posedge clk) begin
    #4;
    if (rst_n) begin
      check({phase, " xfer_addr"}, int'(xfer_addr), m_addr());
      check({phase, " tc"}, int'(tc), m_tc);
      check({phase, " step_ready"}, int'(step_ready), m_ready());
      check({phase, " rdata"}, int'(reg_rdata), m_rdata());
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_valid = 1'b1;
    end
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1
    check("R1 addr", int'(xfer_addr), 0);
    check("R1 tc", int'(tc), 0);
    check("R1 ready", int'(step_ready), 1);

    // R2 R3 R5 R10: wrap mode
    phase = "R5";
    mode = 2'd0;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hFE);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h12);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h00);
    settle();
    check("R2 addr assembled", int'(xfer_addr), 24'h12FFFE);
    steps(4);
    settle();
    check("R5 wrap in window", int'(xfer_addr), 24'h120002);
    check("R10 tc after count+1 steps", int'(tc), 1);
    phase = "R11";
    steps(3);
    settle();
    check("R11 addr frozen", int'(xfer_addr), 24'h120002);
    check("R11 ready low", int'(step_ready), 0);
    wr(2'd3, 8'h00);
    rd(2'd1, rv); check("R10 count low", int'(rv), 8'hFF);
    rd(2'd1, rv); check("R10 count high", int'(rv), 8'hFF);

    // R3 partial count write, clears tc
    phase = "R3";
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h05);
    settle();
    check("R11 tc cleared", int'(tc), 0);
    rd(2'd1, rv); check("R3 high byte kept", int'(rv), 8'hFF);
    wr(2'd3, 8'h00);
    rd(2'd1, rv); check("R3 low byte written", int'(rv), 8'h05);

    // R9 page write in wrap mode
    phase = "R9";
    wr(2'd2, 8'h34);
    settle();
    check("R9 only page changes", int'(xfer_addr), 24'h340002);
    wr(2'd3, 8'h00);
    rd(2'd1, rv); check("R9 count low kept", int'(rv), 8'h05);

    // R12 back-pressure during a write
    phase = "R12";
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd3; step_valid = 1'b1;
    #2 check("R12 ready low on write", int'(step_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0; step_valid = 1'b0;
    settle();
    check("R12 no step taken", int'(xfer_addr), 24'h340002);

    // R6 page step mode
    phase = "R6";
    mode = 2'd1;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h00);
    phase = "R4";
    steps(2);
    settle();
    check("R6 page bumped", int'(xfer_addr), 24'h410001);
    rd(2'd2, rv); check("R6 page read", int'(rv), 8'h41);

    // R7 R8 linear mode
    phase = "R7";
    mode = 2'd2;
    wr(2'd2, 8'h7F);
    settle();
    check("R8 reload on page write", int'(xfer_addr), 24'h7FFFFF);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd1, 8'h00);
    steps(2);
    settle();
    check("R7 carry across 64K", int'(xfer_addr), 24'h800001);
    rd(2'd2, rv); check("R7 page read is bits 23:16", int'(rv), 8'h80);
    phase = "R8";
    wr(2'd2, 8'h05);
    settle();
    check("R8 mid-transfer reload", int'(xfer_addr), 24'h05FFFF);
    wr(2'd3, 8'h00);
    rd(2'd0, rv); check("R8 readback low", int'(rv), 8'hFF);
    rd(2'd0, rv); check("R8 readback high", int'(rv), 8'hFF);
    steps(3);
    settle();
    check("R4 linear steps", int'(xfer_addr), 24'h060002);

    // R1 reset again mid-state
    phase = "R1";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    check("R1 reset addr", int'(xfer_addr), 0);
    rd(2'd2, rv); check("R1 reset page", int'(rv), 0);

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule